// File: doc/BRIEF.md
# Multi-Master Bus Arbiter Agent

This block is the per-master agent that lets one processor share a common system bus with other masters. It reads the processor's 3-bit status code and decides whether the current cycle needs the shared bus. If it does, the agent raises a bus request and waits until it holds priority and the shared busy line is free. It then takes the bus by pulling busy low and enables the processor's command and address drivers. Until that point the address-enable output stays low, so the bus controller and address latches are tri-stated and the processor sees a not-ready bus and waits.

After a transfer the agent keeps the bus parked, so that back-to-back cycles skip re-arbitration. It gives the bus up at a cycle boundary when one of two things happens: priority-in drops because a higher-priority master wants the bus, or the common-request line is active and the any-request strap allows a release. The lock input and the common-request-lock input can each block the release.

Two straps make requests selective:
- In IO-bus mode only memory cycles use the shared bus.
- In resident-bus mode a system/resident select input decides.

Status is captured on the processor clock and brought into the bus clock domain through a synchroniser. Every shared-side transition happens on the bus clock.

The state machine has four states:
- IDLE: neither requesting nor owning the bus.
- REQ: requesting the bus and waiting for it.
- XFER: owning the bus while a cycle is in progress.
- PARK: owning the bus with no cycle in progress.

Its transitions are:
- IDLE→REQ when a cycle needs the bus.
- REQ→XFER when priority-in is high and busy is free.
- REQ→IDLE when the need drops before the grant.
- XFER→PARK when the cycle ends.
- PARK→XFER when a new cycle needs the bus and no release is due.
- PARK→IDLE on a release.

Top module: `mm_bus_agent`

## Requirements
- R1: While init_n is low the agent is in IDLE: bus_req, busy_drive, comreq_drive and addr_en are all 0. After init_n rises the agent owns nothing until it requests again and wins.
- R2: A cycle that needs the bus starts in IDLE. With prio_in high and busy_n high, bus_req rises 4 bus clocks after the status is first sampled. One clock later busy_drive and addr_en rise.
- R3: When the agent requests while busy_n is low or prio_in is low, it holds bus_req=1, comreq_drive=1 and addr_en=0. Once priority and a free bus are both present, it takes the bus on the next bus clock.
- R4: A cycle in progress is never pre-empted. Dropping prio_in during XFER leaves busy_drive and addr_en high until the status returns to idle.
- R5: While lock_n is low the agent keeps the bus, even with prio_in low.
- R6: While crq_lock_n is low the agent keeps the bus against an active common request (comreq_n low), even with strap_any_req high.
- R7: With strap_any_req high, an active common request and crq_lock_n high, the agent releases the bus at the end of the current cycle.
- R8: With strap_any_req low, an active common request alone does not release the bus. A drop of prio_in does release it at the end of the cycle.
- R9: With comreq_n held low and strap_any_req high, the agent releases the bus after every transfer and re-requests for the next one.
- R10: With strap_io_bus high, only status codes with bit 2 set (memory: 100, 101, 110) request the bus. Codes 000, 001 and 010 (interrupt-acknowledge and IO) do not.
- R11: With strap_resident high, a cycle requests the bus only if sys_select is 1. With strap_resident low, sys_select has no effect.
- R12: Status 111 (passive) and 011 (halt) never raise a request. An agent that owns the bus and sees no release condition keeps it parked.
- R13: prio_out equals prio_in AND NOT bus_req on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Processor clock; samples the status code |
| clk_bus | input | 1 | Shared bus clock; all arbitration state |
| init_n | input | 1 | Active-low asynchronous init of all agents |
| cpu_stat | input | 3 | Processor status code (bit 2 = memory) |
| lock_n | input | 1 | Active-low processor lock |
| crq_lock_n | input | 1 | Active-low lock against common requests |
| strap_io_bus | input | 1 | IO-bus mode strap |
| strap_resident | input | 1 | Resident-bus mode strap |
| strap_any_req | input | 1 | Release to any common requester |
| sys_select | input | 1 | 1 = cycle targets the shared system bus |
| prio_in | input | 1 | Priority granted (active high) |
| busy_n | input | 1 | Shared busy line, low = bus owned |
| comreq_n | input | 1 | Shared common request line, low = active |
| bus_req | output | 1 | Bus request to the priority resolver |
| prio_out | output | 1 | Priority passed down the daisy chain |
| busy_drive | output | 1 | 1 pulls the shared busy line low |
| comreq_drive | output | 1 | 1 pulls the common request line low |
| addr_en | output | 1 | 1 enables the command and address drivers |

## Verification
Four properties are checked on every bus clock, and one runs during init:
- the bus is never taken without priority and a free busy line;
- an owned cycle is never dropped;
- lock blocks any release;
- the common-request lock blocks a release to a common requester;
- the agent is idle during init.

Only the bench scenarios can show the rest:
- the exact request latency through the synchroniser;
- the end-of-cycle releases chosen by the straps;
- the forced release after each transfer;
- the command-type and memory-map selection in the two bus modes.

// File: rtl/mm_bus_agent_pkg.sv
package mm_bus_agent_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_PARK = 2'd3
    } agent_state_t;

    localparam logic [STAT_W-1:0] CODE_PASSIVE = 3'b111;
    localparam logic [STAT_W-1:0] CODE_HALT    = 3'b011;

    // Does this status code, under the current straps, need the shared bus?
    function automatic logic cycle_needs_bus(
        input logic [STAT_W-1:0] code,
        input logic              io_mode,
        input logic              res_mode,
        input logic              sel_sys
    );
        logic active;
        logic is_mem;
        active = (code != CODE_PASSIVE) && (code != CODE_HALT);
        is_mem = code[STAT_W-1];
        return active && (!io_mode || is_mem) && (!res_mode || sel_sys);
    endfunction

endpackage

// File: rtl/mm_bus_agent_status.sv
module mm_bus_agent_status
    import mm_bus_agent_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_cpu,
    input  logic              clk_bus,
    input  logic              init_n,
    input  logic [STAT_W-1:0] cpu_stat,
    input  logic              strap_io_bus,
    input  logic              strap_resident,
    input  logic              sys_select,
    output logic              want_sync
);

    logic want_cpu;
    logic [SYNC_STAGES-1:0] chain;

    // Decode on the processor clock.
    always_ff @(posedge clk_cpu or negedge init_n) begin
        if (!init_n) begin
            want_cpu <= 1'b0;
        end else begin
            want_cpu <= cycle_needs_bus(cpu_stat, strap_io_bus, strap_resident, sys_select);
        end
    end

    // Bring the need into the bus clock domain.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk_bus or negedge init_n) begin
                    if (!init_n) chain[0] <= 1'b0;
                    else         chain[0] <= want_cpu;
                end
            end else begin : g_next
                always_ff @(posedge clk_bus or negedge init_n) begin
                    if (!init_n) chain[g] <= 1'b0;
                    else         chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign want_sync = chain[SYNC_STAGES-1];

endmodule

// File: rtl/mm_bus_agent_fsm.sv
module mm_bus_agent_fsm
    import mm_bus_agent_pkg::*;
(
    input  logic clk_bus,
    input  logic init_n,
    input  logic want,
    input  logic lock_n,
    input  logic crq_lock_n,
    input  logic strap_any_req,
    input  logic prio_in,
    input  logic busy_n,
    input  logic comreq_n,
    output logic bus_req,
    output logic busy_drive,
    output logic comreq_drive,
    output logic addr_en
);

    agent_state_t state, state_nx;
    logic bus_free;
    logic release_ok;
    logic owned;

    assign bus_free = busy_n;

    // Release only at a cycle boundary, and never while locked.
    assign release_ok = lock_n &&
                        (!prio_in || (!comreq_n && crq_lock_n && strap_any_req));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (want) state_nx = ST_REQ;
            ST_REQ: begin
                if (!want)                     state_nx = ST_IDLE;
                else if (prio_in && bus_free)  state_nx = ST_XFER;
            end
            ST_XFER: if (!want) state_nx = ST_PARK;
            ST_PARK: begin
                if (release_ok)  state_nx = ST_IDLE;
                else if (want)   state_nx = ST_XFER;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_bus or negedge init_n) begin
        if (!init_n) state <= ST_IDLE;
        else         state <= state_nx;
    end

    always_comb begin
        bus_req      = 1'b0;
        busy_drive   = 1'b0;
        comreq_drive = 1'b0;
        addr_en      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_REQ: begin
                bus_req      = 1'b1;
                comreq_drive = 1'b1;
            end
            ST_XFER, ST_PARK: begin
                bus_req    = 1'b1;
                busy_drive = 1'b1;
                addr_en    = 1'b1;
            end
            default: ;
        endcase
    end

    assign owned = (state == ST_XFER) || (state == ST_PARK);

    assert_take_when_free_R2: assert property (@(posedge clk_bus) disable iff (!init_n)
        $rose(owned) |-> $past(prio_in && busy_n));

    assert_no_preempt_R4: assert property (@(posedge clk_bus) disable iff (!init_n)
        (state == ST_XFER && want) |=> owned);

    assert_hold_locked_R5: assert property (@(posedge clk_bus) disable iff (!init_n)
        (owned && !lock_n) |=> owned);

    assert_crq_lock_R6: assert property (@(posedge clk_bus) disable iff (!init_n)
        (state == ST_PARK && !crq_lock_n && prio_in) |=> owned);

endmodule

// File: rtl/mm_bus_agent.sv
module mm_bus_agent
    import mm_bus_agent_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_cpu,
    input  logic              clk_bus,
    input  logic              init_n,
    input  logic [STAT_W-1:0] cpu_stat,
    input  logic              lock_n,
    input  logic              crq_lock_n,
    input  logic              strap_io_bus,
    input  logic              strap_resident,
    input  logic              strap_any_req,
    input  logic              sys_select,
    input  logic              prio_in,
    input  logic              busy_n,
    input  logic              comreq_n,
    output logic              bus_req,
    output logic              prio_out,
    output logic              busy_drive,
    output logic              comreq_drive,
    output logic              addr_en
);

    logic want_sync;

    mm_bus_agent_status #(.SYNC_STAGES(SYNC_STAGES)) u_status (
        .clk_cpu        (clk_cpu),
        .clk_bus        (clk_bus),
        .init_n         (init_n),
        .cpu_stat       (cpu_stat),
        .strap_io_bus   (strap_io_bus),
        .strap_resident (strap_resident),
        .sys_select     (sys_select),
        .want_sync      (want_sync)
    );

    mm_bus_agent_fsm u_fsm (
        .clk_bus       (clk_bus),
        .init_n        (init_n),
        .want          (want_sync),
        .lock_n        (lock_n),
        .crq_lock_n    (crq_lock_n),
        .strap_any_req (strap_any_req),
        .prio_in       (prio_in),
        .busy_n        (busy_n),
        .comreq_n      (comreq_n),
        .bus_req       (bus_req),
        .busy_drive    (busy_drive),
        .comreq_drive  (comreq_drive),
        .addr_en       (addr_en)
    );

    // Daisy chain: pass priority on only while not requesting.
    assign prio_out = prio_in && !bus_req;

    always @(posedge clk_bus) begin
        if (!init_n) begin
            assert_init_idle_R1: assert (!busy_drive && !addr_en && !bus_req);
        end
    end

endmodule

// File: tb/mm_bus_agent_test.sv
module mm_bus_agent_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       init_n = 1'b0;
    logic [2:0] cpu_stat = 3'b111;
    logic       lock_n = 1'b1, crq_lock_n = 1'b1;
    logic       strap_io_bus = 1'b0, strap_resident = 1'b0, strap_any_req = 1'b0;
    logic       sys_select = 1'b0, prio_in = 1'b1;
    logic       other_busy = 1'b0, other_comreq = 1'b0;
    logic       bus_req, prio_out, busy_drive, comreq_drive, addr_en;
    logic       busy_n, comreq_n;

    assign busy_n   = ~(busy_drive | other_busy);
    assign comreq_n = ~(comreq_drive | other_comreq);

    int tests = 0;
    int fails = 0;

    mm_bus_agent uut (
        .clk_cpu(clk), .clk_bus(clk), .init_n(init_n), .cpu_stat(cpu_stat),
        .lock_n(lock_n), .crq_lock_n(crq_lock_n), .strap_io_bus(strap_io_bus),
        .strap_resident(strap_resident), .strap_any_req(strap_any_req),
        .sys_select(sys_select), .prio_in(prio_in), .busy_n(busy_n),
        .comreq_n(comreq_n), .bus_req(bus_req), .prio_out(prio_out),
        .busy_drive(busy_drive), .comreq_drive(comreq_drive), .addr_en(addr_en)
    );

    function automatic logic exp_need(input logic [2:0] s, input logic iob,
                                      input logic resb, input logic sel);
        logic idle_code;
        idle_code = (s == 3'b111) || (s == 3'b011);
        return !idle_code && (!iob || s[2]) && (!resb || sel);
    endfunction

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic restart();
        @(negedge clk);
        init_n = 1'b0;
        cpu_stat = 3'b111; lock_n = 1'b1; crq_lock_n = 1'b1;
        strap_io_bus = 1'b0; strap_resident = 1'b0; strap_any_req = 1'b0;
        sys_select = 1'b0; prio_in = 1'b1; other_busy = 1'b0; other_comreq = 1'b0;
        edges(2);
        @(negedge clk);
        init_n = 1'b1;
        edges(1);
    endtask

    task automatic set_stat(input logic [2:0] s);
        @(negedge clk);
        cpu_stat = s;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        edges(2);
        chk("R1 busy", busy_drive, 1'b0);
        chk("R1 aen", addr_en, 1'b0);
        chk("R1 breq", bus_req, 1'b0);
        restart();
        chk("R1 after init", busy_drive, 1'b0);

        // R2 exact latency
        set_stat(3'b101);
        edges(4);
        chk("R2 breq at 4", bus_req, 1'b1);
        chk("R2 aen not yet", addr_en, 1'b0);
        edges(1);
        chk("R2 busy at 5", busy_drive, 1'b1);
        chk("R2 aen at 5", addr_en, 1'b1);
        chk("R13 prio_out while req", prio_out, 1'b0);

        // R3 wait while bus busy
        restart();
        other_busy = 1'b1;
        set_stat(3'b110);
        edges(8);
        chk("R3 breq", bus_req, 1'b1);
        chk("R3 comreq", comreq_drive, 1'b1);
        chk("R3 aen low", addr_en, 1'b0);
        @(negedge clk); other_busy = 1'b0;
        edges(1);
        chk("R3 take", busy_drive, 1'b1);

        // R4 no preemption, then R8 release on priority loss
        @(negedge clk); prio_in = 1'b0;
        edges(6);
        chk("R4 held", addr_en, 1'b1);
        set_stat(3'b111);
        edges(8);
        chk("R8 release on prio loss", busy_drive, 1'b0);

        // R5 lock
        restart();
        set_stat(3'b101);
        edges(6);
        @(negedge clk); lock_n = 1'b0; prio_in = 1'b0; cpu_stat = 3'b111;
        edges(8);
        chk("R5 locked hold", busy_drive, 1'b1);
        @(negedge clk); lock_n = 1'b1;
        edges(2);
        chk("R5 release after unlock", busy_drive, 1'b0);

        // R6 crq lock, then R7 any-request release
        restart();
        strap_any_req = 1'b1;
        set_stat(3'b101);
        edges(6);
        @(negedge clk); crq_lock_n = 1'b0; other_comreq = 1'b1; cpu_stat = 3'b111;
        edges(8);
        chk("R6 crq hold", busy_drive, 1'b1);
        @(negedge clk); crq_lock_n = 1'b1;
        edges(2);
        chk("R7 any-req release", busy_drive, 1'b0);

        // R8 comreq without any-request keeps bus, R12 parked
        restart();
        set_stat(3'b100);
        edges(6);
        @(negedge clk); other_comreq = 1'b1; cpu_stat = 3'b111;
        edges(8);
        chk("R8 comreq ignored", busy_drive, 1'b1);
        chk("R12 parked", addr_en, 1'b1);

        // R9 forced release after every transfer
        restart();
        strap_any_req = 1'b1; other_comreq = 1'b1;
        for (int k = 0; k < 3; k++) begin
            set_stat(3'b110);
            edges(8);
            chk("R9 acquire", busy_drive, 1'b1);
            set_stat(3'b111);
            edges(8);
            chk("R9 forced release", busy_drive, 1'b0);
        end

        // R10 IO-bus mode
        restart();
        strap_io_bus = 1'b1;
        set_stat(3'b001);
        edges(8);
        chk("R10 io no req", bus_req, 1'b0);
        set_stat(3'b000);
        edges(8);
        chk("R10 intack no req", bus_req, 1'b0);
        set_stat(3'b110);
        edges(8);
        chk("R10 mem req", busy_drive, 1'b1);

        // R11 resident mode
        restart();
        strap_resident = 1'b1; sys_select = 1'b0;
        set_stat(3'b101);
        edges(8);
        chk("R11 resident no req", bus_req, 1'b0);
        @(negedge clk); sys_select = 1'b1;
        edges(8);
        chk("R11 system req", busy_drive, 1'b1);
        restart();
        sys_select = 1'b0;
        set_stat(3'b101);
        edges(8);
        chk("R11 select ignored", busy_drive, 1'b1);

        // R12 halt
        restart();
        set_stat(3'b011);
        edges(8);
        chk("R12 halt no req", bus_req, 1'b0);
        chk("R13 prio_out idle", prio_out, 1'b1);

        // Random: straps, status and select against the need model
        void'($urandom(32'd1234));
        for (int i = 0; i < 40; i++) begin
            logic [2:0] s;
            logic iob, resb, sel, pin;
            restart();
            s = 3'($urandom); iob = 1'($urandom); resb = 1'($urandom);
            sel = 1'($urandom); pin = 1'($urandom);
            @(negedge clk);
            strap_io_bus = iob; strap_resident = resb; sys_select = sel;
            cpu_stat = s; prio_in = pin;
            edges(8);
            chk("R10/R11/R12 random req", bus_req, exp_need(s, iob, resb, sel));
            chk("R2 random own", busy_drive, exp_need(s, iob, resb, sel) && pin);
            chk("R13 random prio_out", prio_out, pin && !exp_need(s, iob, resb, sel));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule